// File: doc/BRIEF.md
# UART Software Flow Control Engine

This block applies in-band pause/resume flow control to one UART channel. It sits between the receive deserializer, the receive FIFO and the transmit scheduler. Every received character is compared against two programmable flow-control characters, a pause character and a resume character. A transparency setting decides whether matched characters are stored in the receive FIFO or dropped. A character counts only when the FIFO has room for it and no overrun came with it. A break is treated as a received 0x00.

The transmitter is gated by a two-bit mode field. In host mode only processor commands halt and resume it. In auto-transmit mode a received pause character stops new transmissions until a resume character arrives, and transmitter commands are ignored while that halt holds. With auto-receive set, the block watches the receive FIFO fill level and asks the scheduler to insert pause and resume characters, with hysteresis between a high and a low watermark. A soft-reset command flushes the transmit FIFO and returns the block to its defaults.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset the pause character is 0x13, the resume character is 0x11 and `tx_gate_o` is 1. A write with `char_sel_i`=0 loads the pause character and a write with `char_sel_i`=1 loads the resume character. All matching uses the current register contents.
- R2: A received character that is accepted (no overrun and room in the FIFO) is pushed, one cycle after `rx_valid_i`, on `rx_push_o`/`rx_push_data_o`. The exception is a character that matches a flow-control character while `strip_i`=1; that character is not pushed. With `strip_i`=0 matched characters are pushed as well.
- R3: With `mode_i[0]`=1 (auto-transmit), an accepted pause character drives `tx_gate_o` low from the next cycle. An accepted resume character drives it high again from the next cycle.
- R4: While halted by a received pause character, the commands transmit enable (00001), transmit disable (00010), halt (10101) and resume (10110) have no effect.
- R5: With `mode_i[0]`=0 (host), command 10101 lowers `tx_gate_o` and only command 10110 or a reset raises it. Received resume characters, disable and enable commands do not raise it. Repeated halt or resume commands change nothing, and resume while not halted has no effect. Received characters never halt in host mode.
- R6: A character that comes with `rx_overrun_i`=1, or that arrives while `rx_level_i` equals FIFO_DEPTH, is not pushed and does not affect the transmitter, whatever `strip_i` is.
- R7: With `rx_break_i`=1 the received character is taken as 0x00 for both matching and pushing.
- R8: With `mode_i[1]`=1 (auto-receive) and the remote side not paused, a level of at least HI_MARK raises `tx_inject_o` with the pause character on the next cycle. After that pause has been sent, a level at or below LO_MARK raises it with the resume character. `tx_inject_o` holds until a cycle with `tx_ready_i`=1 and drops the cycle after. `tx_gate_o` is 0 while `tx_inject_o` is 1.
- R9: Command 00011 (soft reset) pulses `tx_flush_o` in the next cycle. It also clears every halt and any pending insertion, and restores the default characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Bit 0 auto-transmit, bit 1 auto-receive; 00 is host mode |
| strip_i | input | 1 | 1 drops matched flow-control characters |
| char_wr_i | input | 1 | Write strobe for a flow-control character |
| char_sel_i | input | 1 | 0 pause character, 1 resume character |
| char_data_i | input | 8 | Character value to write |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 5 | Command code |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character |
| rx_break_i | input | 1 | Break received; character is 0x00 |
| rx_overrun_i | input | 1 | Receiver overrun with this character |
| rx_level_i | input | LW | Receive FIFO fill level |
| rx_push_o | output | 1 | Push into receive FIFO |
| rx_push_data_o | output | 8 | Character to push |
| tx_ready_i | input | 1 | Transmitter at a character boundary, taking a character |
| tx_gate_o | output | 1 | Transmit FIFO data may start |
| tx_inject_o | output | 1 | Flow-control character requested |
| tx_inject_char_o | output | 8 | Character to insert |
| tx_flush_o | output | 1 | Discard transmit FIFO contents |

## Verification
Every result is registered, so each one is due exactly one cycle after the clock edge that sees its stimulus. This holds for the FIFO push, gate changes from characters or commands, an insertion request after a level change or its removal after `tx_ready_i`, and the flush pulse. The bench drives each stimulus for a single cycle on a falling edge and samples on the next falling edge, which is the first point where the registered result is visible. Expected pushes go into a queue that a monitor drains on falling edges. Dropped characters are checked as an absent push in that same sampling cycle.

// File: rtl/flow_pkg.sv
`timescale 1ns/1ps
package flow_pkg;
  localparam int CHAR_W = 8;
  typedef logic [CHAR_W-1:0] char_t;

  localparam char_t PAUSE_DEFAULT  = 8'h13;
  localparam char_t RESUME_DEFAULT = 8'h11;

  localparam logic [4:0] CMD_TX_EN    = 5'b00001;
  localparam logic [4:0] CMD_TX_DIS   = 5'b00010;
  localparam logic [4:0] CMD_SOFT_RST = 5'b00011;
  localparam logic [4:0] CMD_HALT     = 5'b10101;
  localparam logic [4:0] CMD_RESUME   = 5'b10110;

  typedef enum logic [1:0] {
    INJ_NONE   = 2'd0,
    INJ_PAUSE  = 2'd1,
    INJ_RESUME = 2'd2
  } inj_e;
endpackage

// File: rtl/flow_char_match.sv
`timescale 1ns/1ps
module flow_char_match
  import flow_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  soft_rst_i,
  input  logic  wr_i,
  input  logic  wr_sel_i,
  input  char_t wr_data_i,
  input  logic  rx_valid_i,
  input  char_t rx_data_i,
  input  logic  rx_break_i,
  input  logic  rx_overrun_i,
  input  logic  room_i,
  input  logic  strip_i,
  output logic  hit_pause_o,
  output logic  hit_resume_o,
  output logic  push_o,
  output char_t push_data_o,
  output char_t pause_char_o,
  output char_t resume_char_o
);
  char_t pause_q, resume_q, chr;
  logic  accept, is_pause, is_resume;
  logic  push_q;
  char_t push_data_q;

  assign chr       = rx_break_i ? '0 : rx_data_i;
  assign accept    = rx_valid_i & ~rx_overrun_i & room_i;
  assign is_pause  = (chr == pause_q);
  assign is_resume = (chr == resume_q);

  assign hit_pause_o  = accept & is_pause;
  assign hit_resume_o = accept & is_resume;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_q  <= PAUSE_DEFAULT;
      resume_q <= RESUME_DEFAULT;
    end else if (soft_rst_i) begin
      pause_q  <= PAUSE_DEFAULT;
      resume_q <= RESUME_DEFAULT;
    end else if (wr_i) begin
      if (wr_sel_i) resume_q <= wr_data_i;
      else          pause_q  <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_q      <= 1'b0;
      push_data_q <= '0;
    end else begin
      push_q      <= accept & ~(strip_i & (is_pause | is_resume));
      push_data_q <= chr;
    end
  end

  assign push_o        = push_q;
  assign push_data_o   = push_data_q;
  assign pause_char_o  = pause_q;
  assign resume_char_o = resume_q;
endmodule

// File: rtl/flow_tx_gate.sv
`timescale 1ns/1ps
module flow_tx_gate
  import flow_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       auto_tx_i,
  input  logic       soft_rst_i,
  input  logic       cmd_valid_i,
  input  logic [4:0] cmd_code_i,
  input  logic       hit_pause_i,
  input  logic       hit_resume_i,
  input  logic       inject_busy_i,
  output logic       gate_o
);
  logic en_q, host_halt_q, auto_halt_q;
  logic cmd_live;

  // transmitter commands are dead while a received pause holds
  assign cmd_live = cmd_valid_i & ~auto_halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b1;
      host_halt_q <= 1'b0;
      auto_halt_q <= 1'b0;
    end else if (soft_rst_i) begin
      host_halt_q <= 1'b0;
      auto_halt_q <= 1'b0;
    end else begin
      if (cmd_live) begin
        case (cmd_code_i)
          CMD_TX_EN:  en_q <= 1'b1;
          CMD_TX_DIS: en_q <= 1'b0;
          CMD_HALT:   if (!auto_tx_i) host_halt_q <= 1'b1;
          CMD_RESUME: if (!auto_tx_i) host_halt_q <= 1'b0;
          default: ;
        endcase
      end
      if (auto_tx_i) begin
        if (hit_pause_i)       auto_halt_q <= 1'b1;
        else if (hit_resume_i) auto_halt_q <= 1'b0;
      end
    end
  end

  assign gate_o = en_q & ~host_halt_q & ~auto_halt_q & ~inject_busy_i;
endmodule

// File: rtl/flow_auto_insert.sv
`timescale 1ns/1ps
module flow_auto_insert
  import flow_pkg::*;
#(
  parameter int LW      = 9,
  parameter int HI_MARK = 192,
  parameter int LO_MARK = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          soft_rst_i,
  input  logic [LW-1:0] level_i,
  input  logic          tx_ready_i,
  input  char_t         pause_char_i,
  input  char_t         resume_char_i,
  output logic          inject_o,
  output char_t         inject_char_o
);
  localparam logic [LW-1:0] HI = LW'(HI_MARK);
  localparam logic [LW-1:0] LO = LW'(LO_MARK);

  inj_e pend_q;
  logic remote_paused_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q          <= INJ_NONE;
      remote_paused_q <= 1'b0;
    end else if (soft_rst_i) begin
      pend_q          <= INJ_NONE;
      remote_paused_q <= 1'b0;
    end else if (pend_q != INJ_NONE) begin
      if (tx_ready_i) begin
        remote_paused_q <= (pend_q == INJ_PAUSE);
        pend_q          <= INJ_NONE;
      end
    end else if (enable_i) begin
      if (!remote_paused_q && level_i >= HI)     pend_q <= INJ_PAUSE;
      else if (remote_paused_q && level_i <= LO) pend_q <= INJ_RESUME;
    end
  end

  assign inject_o      = (pend_q != INJ_NONE);
  assign inject_char_o = (pend_q == INJ_PAUSE) ? pause_char_i : resume_char_i;
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
`timescale 1ns/1ps
module xonxoff_flow_ctrl
  import flow_pkg::*;
#(
  parameter int FIFO_DEPTH = 256,
  parameter int HI_MARK    = 192,
  parameter int LO_MARK    = 64,
  localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          strip_i,
  input  logic          char_wr_i,
  input  logic          char_sel_i,
  input  logic [7:0]    char_data_i,
  input  logic          cmd_valid_i,
  input  logic [4:0]    cmd_code_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_break_i,
  input  logic          rx_overrun_i,
  input  logic [LW-1:0] rx_level_i,
  output logic          rx_push_o,
  output logic [7:0]    rx_push_data_o,
  input  logic          tx_ready_i,
  output logic          tx_gate_o,
  output logic          tx_inject_o,
  output logic [7:0]    tx_inject_char_o,
  output logic          tx_flush_o
);
  logic  soft_rst, room, hit_pause, hit_resume, flush_q;
  char_t pause_char, resume_char;

  assign soft_rst = cmd_valid_i & (cmd_code_i == CMD_SOFT_RST);
  assign room     = rx_level_i < LW'(FIFO_DEPTH);

  flow_char_match i_match (
    .clk_i, .rst_ni,
    .soft_rst_i   (soft_rst),
    .wr_i         (char_wr_i),
    .wr_sel_i     (char_sel_i),
    .wr_data_i    (char_data_i),
    .rx_valid_i,
    .rx_data_i,
    .rx_break_i,
    .rx_overrun_i,
    .room_i       (room),
    .strip_i,
    .hit_pause_o  (hit_pause),
    .hit_resume_o (hit_resume),
    .push_o       (rx_push_o),
    .push_data_o  (rx_push_data_o),
    .pause_char_o (pause_char),
    .resume_char_o(resume_char)
  );

  flow_tx_gate i_gate (
    .clk_i, .rst_ni,
    .auto_tx_i    (mode_i[0]),
    .soft_rst_i   (soft_rst),
    .cmd_valid_i,
    .cmd_code_i,
    .hit_pause_i  (hit_pause),
    .hit_resume_i (hit_resume),
    .inject_busy_i(tx_inject_o),
    .gate_o       (tx_gate_o)
  );

  flow_auto_insert #(.LW(LW), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) i_insert (
    .clk_i, .rst_ni,
    .enable_i     (mode_i[1]),
    .soft_rst_i   (soft_rst),
    .level_i      (rx_level_i),
    .tx_ready_i,
    .pause_char_i (pause_char),
    .resume_char_i(resume_char),
    .inject_o     (tx_inject_o),
    .inject_char_o(tx_inject_char_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= soft_rst;
  end
  assign tx_flush_o = flush_q;
endmodule

// File: rtl/flow_ctrl_checker.sv
`timescale 1ns/1ps
module flow_ctrl_checker
  import flow_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int LW    = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          auto_tx_i,
  input logic          strip_i,
  input logic          char_wr_i,
  input logic          cmd_valid_i,
  input logic [4:0]    cmd_code_i,
  input logic          rx_valid_i,
  input logic [7:0]    rx_data_i,
  input logic          rx_break_i,
  input logic          rx_overrun_i,
  input logic [LW-1:0] rx_level_i,
  input logic          rx_push_o,
  input logic [7:0]    rx_push_data_o,
  input logic          tx_ready_i,
  input logic          tx_gate_o,
  input logic          tx_inject_o,
  input logic [7:0]    tx_inject_char_o,
  input logic          tx_flush_o,
  input logic [7:0]    pause_char,
  input logic [7:0]    resume_char
);
  logic [7:0] chr;
  logic       ok_in, srst;
  assign chr   = rx_break_i ? 8'h00 : rx_data_i;
  assign ok_in = rx_valid_i && !rx_overrun_i && (rx_level_i < LW'(DEPTH));
  assign srst  = cmd_valid_i && cmd_code_i == CMD_SOFT_RST;

  AST_OVERRUN_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && rx_overrun_i |=> !rx_push_o); // R6
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && rx_level_i >= LW'(DEPTH) |=> !rx_push_o); // R6
  AST_STRIP_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_in && strip_i && (chr == pause_char || chr == resume_char) |=> !rx_push_o); // R2
  AST_PLAIN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_in && !rx_break_i && rx_data_i != pause_char && rx_data_i != resume_char
    |=> rx_push_o && rx_push_data_o == $past(rx_data_i)); // R2
  AST_BREAK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && rx_break_i |=> !rx_push_o || rx_push_data_o == 8'h00); // R7
  AST_AUTO_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_tx_i && ok_in && chr == pause_char && !srst |=> !tx_gate_o); // R3
  AST_INJECT_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_inject_o |-> !tx_gate_o); // R8
  AST_INJECT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_inject_o && !tx_ready_i && !srst && !char_wr_i
    |=> tx_inject_o && $stable(tx_inject_char_o)); // R8
  AST_FLUSH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> tx_flush_o && !tx_inject_o && pause_char == 8'h13 && resume_char == 8'h11); // R9
endmodule

bind xonxoff_flow_ctrl flow_ctrl_checker #(.DEPTH(FIFO_DEPTH), .LW(LW)) i_chk (
  .clk_i, .rst_ni,
  .auto_tx_i(mode_i[0]),
  .strip_i, .char_wr_i, .cmd_valid_i, .cmd_code_i,
  .rx_valid_i, .rx_data_i, .rx_break_i, .rx_overrun_i, .rx_level_i,
  .rx_push_o, .rx_push_data_o, .tx_ready_i, .tx_gate_o,
  .tx_inject_o, .tx_inject_char_o, .tx_flush_o,
  .pause_char, .resume_char
);

// File: tb/test_xonxoff_flow_ctrl.sv
`timescale 1ns/1ps
module test_xonxoff_flow_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic strip = 1'b0, char_wr = 1'b0, char_sel = 1'b0;
  logic [7:0] char_data = '0;
  logic cmd_valid = 1'b0;
  logic [4:0] cmd_code = '0;
  logic rx_valid = 1'b0, rx_break = 1'b0, rx_overrun = 1'b0;
  logic [7:0] rx_data = '0;
  logic [LW-1:0] rx_level = '0;
  logic tx_ready = 1'b0;
  logic rx_push, tx_gate, tx_inject, tx_flush;
  logic [7:0] rx_push_data, tx_inject_char;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xonxoff_flow_ctrl i_xonxoff_flow_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .strip_i(strip),
    .char_wr_i(char_wr), .char_sel_i(char_sel), .char_data_i(char_data),
    .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_break_i(rx_break),
    .rx_overrun_i(rx_overrun), .rx_level_i(rx_level),
    .rx_push_o(rx_push), .rx_push_data_o(rx_push_data),
    .tx_ready_i(tx_ready), .tx_gate_o(tx_gate), .tx_inject_o(tx_inject),
    .tx_inject_char_o(tx_inject_char), .tx_flush_o(tx_flush)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: every push must match the next expected character (R2, R7)
  always @(negedge clk) begin
    if (rst_n && rx_push) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected push", {24'd0, rx_push_data}, 32'hffff);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_push_data == e, "R2 push data", {24'd0, rx_push_data}, {24'd0, e});
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit brk, input bit ovr,
                      input bit exp_push, input logic [7:0] exp_d, input string req);
    rx_valid = 1'b1; rx_data = d; rx_break = brk; rx_overrun = ovr;
    if (exp_push) exp_q.push_back(exp_d);
    step();
    rx_valid = 1'b0; rx_break = 1'b0; rx_overrun = 1'b0;
    if (!exp_push) chk(rx_push == 1'b0, req, {31'd0, rx_push}, 32'd0);
  endtask

  task automatic cmd(input logic [4:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic wr_char(input bit sel, input logic [7:0] d);
    char_wr = 1'b1; char_sel = sel; char_data = d;
    step();
    char_wr = 1'b0;
  endtask

  task automatic gate_is(input bit e, input string req);
    chk(tx_gate == e, req, {31'd0, tx_gate}, {31'd0, e});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    gate_is(1'b1, "R1 gate after reset");
    chk(!rx_push && !tx_inject && !tx_flush, "R1 outputs idle", {29'd0, rx_push, tx_inject, tx_flush}, 32'd0);

    // R2 transparent, host mode: received pause does not halt (R5)
    send(8'h41, 0, 0, 1, 8'h41, "R2");
    send(8'h13, 0, 0, 1, 8'h13, "R2");
    gate_is(1'b1, "R5 rx pause ignored in host mode");
    strip = 1'b1;
    send(8'h11, 0, 0, 0, 8'h00, "R2 stripped resume");
    send(8'h42, 0, 0, 1, 8'h42, "R2");

    // R1 writable register used for matching
    wr_char(1'b0, 8'h55);
    send(8'h13, 0, 0, 1, 8'h13, "R1 old pause no longer matches");
    send(8'h55, 0, 0, 0, 8'h00, "R1 new pause stripped");
    wr_char(1'b0, 8'h13);

    // R3 auto-transmit halt / resume, R4 commands ignored while halted
    mode = 2'b01;
    send(8'h13, 0, 0, 0, 8'h00, "R3");
    gate_is(1'b0, "R3 halted by rx pause");
    cmd(5'b00001); cmd(5'b10110);
    gate_is(1'b0, "R4 enable/resume ignored");
    cmd(5'b00010);
    send(8'h11, 0, 0, 0, 8'h00, "R3");
    gate_is(1'b1, "R4 disable ignored, R3 resumed by rx resume");

    // R5 host mode commands
    mode = 2'b00;
    cmd(5'b10110);
    gate_is(1'b1, "R5 resume while running");
    cmd(5'b10101);
    gate_is(1'b0, "R5 halt cmd");
    cmd(5'b10101);
    gate_is(1'b0, "R5 repeated halt");
    send(8'h11, 0, 0, 0, 8'h00, "R5");
    gate_is(1'b0, "R5 rx resume ignored");
    cmd(5'b00010); cmd(5'b00001);
    gate_is(1'b0, "R5 disable/enable does not resume");
    cmd(5'b10110);
    gate_is(1'b1, "R5 resume cmd");
    cmd(5'b10110);
    gate_is(1'b1, "R5 repeated resume");

    // R6 overrun and full FIFO
    mode = 2'b01; strip = 1'b0;
    send(8'h13, 0, 1, 0, 8'h00, "R6 overrun not stored");
    gate_is(1'b1, "R6 overrun pause ignored");
    rx_level = 9'd256;
    send(8'h13, 0, 0, 0, 8'h00, "R6 full not stored");
    gate_is(1'b1, "R6 full pause ignored");
    send(8'h41, 0, 0, 0, 8'h00, "R6 full plain dropped");
    rx_level = 9'd255;
    send(8'h41, 0, 0, 1, 8'h41, "R6 room for one");
    rx_level = 9'd0;

    // R7 break as 0x00
    wr_char(1'b0, 8'h00);
    send(8'h7e, 1, 0, 1, 8'h00, "R7");
    gate_is(1'b0, "R7 break matched zero pause");

    // R9 soft reset
    cmd(5'b00011);
    chk(tx_flush == 1'b1, "R9 flush pulse", {31'd0, tx_flush}, 32'd1);
    gate_is(1'b1, "R9 halt cleared");
    step();
    chk(tx_flush == 1'b0, "R9 flush one cycle", {31'd0, tx_flush}, 32'd0);
    strip = 1'b1;
    send(8'h00, 0, 0, 1, 8'h00, "R9 zero no longer matches");
    send(8'h13, 0, 0, 0, 8'h00, "R9 default pause restored");
    gate_is(1'b0, "R9 default pause halts");
    send(8'h11, 0, 0, 0, 8'h00, "R9 default resume restored");

    // R8 full auto insertion
    mode = 2'b10;
    rx_level = 9'd191; step();
    chk(tx_inject == 1'b0, "R8 below high mark", {31'd0, tx_inject}, 32'd0);
    rx_level = 9'd192; step();
    chk(tx_inject == 1'b1 && tx_inject_char == 8'h13, "R8 pause inject",
        {23'd0, tx_inject, tx_inject_char}, 32'h113);
    gate_is(1'b0, "R8 inject has priority");
    step(); step();
    chk(tx_inject == 1'b1, "R8 inject held", {31'd0, tx_inject}, 32'd1);
    tx_ready = 1'b1; step(); tx_ready = 1'b0;
    chk(tx_inject == 1'b0, "R8 inject consumed", {31'd0, tx_inject}, 32'd0);
    gate_is(1'b1, "R8 gate back");
    step();
    chk(tx_inject == 1'b0, "R8 no repeat pause", {31'd0, tx_inject}, 32'd0);
    rx_level = 9'd65; step();
    chk(tx_inject == 1'b0, "R8 above low mark", {31'd0, tx_inject}, 32'd0);
    rx_level = 9'd64; step();
    chk(tx_inject == 1'b1 && tx_inject_char == 8'h11, "R8 resume inject",
        {23'd0, tx_inject, tx_inject_char}, 32'h111);
    tx_ready = 1'b1; step(); tx_ready = 1'b0;
    rx_level = 9'd100; step();
    chk(tx_inject == 1'b0, "R8 hysteresis band", {31'd0, tx_inject}, 32'd0);
    rx_level = 9'd200; step();
    chk(tx_inject == 1'b1, "R8 pause again", {31'd0, tx_inject}, 32'd1);
    cmd(5'b00011);
    rx_level = 9'd0;
    chk(tx_inject == 1'b0 && tx_flush == 1'b1, "R9 pending insertion cleared",
        {30'd0, tx_inject, tx_flush}, 32'd1);

    repeat (3) step();
    chk(exp_q.size() == 0, "R2 all pushes seen", exp_q.size(), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule